// File: doc/BRIEF.md
# Stride Value Predictor

This block predicts the result of an instruction before it executes. It keeps a direct-mapped table indexed by the instruction address. Each entry holds the most recent committed result and the difference between the two most recent results. The predicted value is the last value plus that difference. The pipeline looks up the table with the fetch address and gets the answer one cycle later. At commit it trains the table with the address, the real result and a flag that says whether the earlier prediction was right.

Several instances of the same instruction can be in flight at once, so the table's last value may be stale. A small FIFO window therefore records the value predicted for every looked-up instance that hit the table. A later lookup of the same address extrapolates from the youngest of these values. The window drains in order as matching instructions commit, and a squash empties it.

A prediction is handed to the pipeline only at very high confidence. Each entry has a saturating confidence counter. A misprediction sets it to zero. A correct outcome raises it by one only when a pseudo-random gate opens, with probability 1/32 or 1/256 as configured.

Top module: `stride_value_predictor`

## Requirements
- R1: A lookup (`lk_valid`) gives `pr_valid` high exactly one cycle later. The entry index is `pc[7:2]` and the stored tag is `pc[15:8]`. `pr_hit` is high when that entry is valid and its tag matches. On a miss, `pr_value` is 0.
- R2: On a hit, `pr_value` is a base value plus the entry's stride, modulo 2^32. The stride is the newer committed result minus the previous one.
- R3: The base value is taken from the youngest window entry whose full 32-bit PC equals the lookup PC. If no window entry matches, the base is the table's last value. The lookup sees the window as it was before that clock edge.
- R4: `pr_use` is high only when three things hold: the entry hits, its 3-bit confidence is 7, and the matching window entry (if there is one) was recorded while its table entry was at confidence 7.
- R5: A commit that hits with `cm_ok`=0 sets confidence to 0. A commit that hits with `cm_ok`=1 adds 1 only in a cycle where the gate is open, and confidence stops at 7. Last value and stride are updated on every hitting commit.
- R6: The gate comes from a 16-bit LFSR. It is seeded with 0xACE1 in reset and advances every cycle after reset: it shifts left, and bit0 takes `s[15]^s[13]^s[12]^s[10]`. The gate is open when the low 5 bits are all zero (`cfg_rare`=0) or when the low 8 bits are all zero (`cfg_rare`=1).
- R7: A commit that misses the tag allocates the entry with last value = the committed result, stride 0 and confidence 0. A lookup that misses allocates it with last value 0, stride 0 and confidence 0.
- R8: When a commit and a lookup-miss allocation target the same index in one cycle, the commit's update wins and the allocation is dropped.
- R9: Every lookup that hits pushes its predicted value into the window, unless the window already holds 8 entries; in that case the push is dropped.
- R10: A commit whose PC equals the oldest window entry's PC removes that entry. `squash` empties the window and overrides a push in the same cycle.
- R11: After reset, `pr_valid`, `pr_hit` and `pr_use` are 0, all table entries are invalid and the window is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rare | input | 1 | Gate probability select: 0 gives 1/32, 1 gives 1/256 |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Lookup instruction address |
| squash | input | 1 | Empty the speculative window |
| cm_valid | input | 1 | Commit (training) request |
| cm_pc | input | 32 | Committing instruction address |
| cm_value | input | 32 | Committed result |
| cm_ok | input | 1 | Earlier prediction for this instance was correct |
| pr_valid | output | 1 | Response to the previous cycle's lookup |
| pr_hit | output | 1 | Lookup matched a table entry |
| pr_value | output | 32 | Predicted value |
| pr_use | output | 1 | Prediction is confident enough to use |

## Verification
Linear sequences with several strides train entries to saturation. The bench probes each entry at confidence 6 and again at 7, which separates a gated increment from an ungated one under both probability settings. Back-to-back lookups of one address, with no commits in between, show whether extrapolation chains through the window or falls back to the table. A run that fills the window, commits the head and then looks up again shows both the full-window drop and the in-order retire. A mispredicted commit, a window entry recorded at low confidence, and a commit and allocation that meet at the same index each single out one qualifying rule.

// File: rtl/svp_pkg.sv
package svp_pkg;
  localparam int VP_DATA_W      = 32;
  localparam int VP_PC_W        = 32;
  localparam int VP_RNG_W       = 16;
  localparam int VP_COMMON_BITS = 5;
  localparam int VP_RARE_BITS   = 8;
  localparam logic [VP_RNG_W-1:0] VP_RNG_SEED = 16'hACE1;

  typedef logic [VP_DATA_W-1:0] vp_data_t;
  typedef logic [VP_PC_W-1:0]   vp_pc_t;
  typedef logic [VP_RNG_W-1:0]  vp_rng_t;

  // next value in an arithmetic run
  function automatic vp_data_t vp_extrapolate(vp_data_t base, vp_data_t step);
    return base + step;
  endfunction

  // difference between consecutive committed results
  function automatic vp_data_t vp_delta(vp_data_t newer, vp_data_t older);
    return newer - older;
  endfunction

  // left-shifting Fibonacci register, feedback from bits 15,13,12,10
  function automatic vp_rng_t vp_rng_advance(vp_rng_t s);
    return {s[VP_RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // open when the selected low bits are all zero
  function automatic logic vp_gate_open(vp_rng_t s, logic rare);
    vp_rng_t mask;
    mask = rare ? vp_rng_t'((1 << VP_RARE_BITS) - 1)
                : vp_rng_t'((1 << VP_COMMON_BITS) - 1);
    return (s & mask) == '0;
  endfunction
endpackage

// File: rtl/svp_rng_gate.sv
module svp_rng_gate
  import svp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rare,
  output vp_rng_t state_o,
  output logic    gate_o
);
  vp_rng_t state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= VP_RNG_SEED;
    else        state_q <= vp_rng_advance(state_q);
  end

  assign state_o = state_q;
  assign gate_o  = vp_gate_open(state_q, rare);
endmodule

// File: rtl/svp_table.sv
module svp_table
  import svp_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 8,
  parameter int CONF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  // read port
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output vp_data_t         rd_last,
  output vp_data_t         rd_stride,
  output logic             rd_sat,
  // training port
  input  logic             tr_valid,
  input  logic [IDX_W-1:0] tr_idx,
  input  logic [TAG_W-1:0] tr_tag,
  input  vp_data_t         tr_value,
  input  logic             tr_ok,
  input  logic             gate,
  // allocation port
  input  logic             al_valid,
  input  logic [IDX_W-1:0] al_idx,
  input  logic [TAG_W-1:0] al_tag,
  // events
  output logic             ev_inc,
  output logic             ev_clr,
  output logic             ev_al_go
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CONF_W-1:0] CONF_TOP = {CONF_W{1'b1}};

  logic              vld_q    [ENTRIES];
  logic [TAG_W-1:0]  tag_q    [ENTRIES];
  vp_data_t          last_q   [ENTRIES];
  vp_data_t          stride_q [ENTRIES];
  logic [CONF_W-1:0] conf_q   [ENTRIES];

  function automatic logic [CONF_W-1:0] conf_after(logic [CONF_W-1:0] c,
                                                    logic ok, logic open);
    if (!ok)                      return '0;
    else if (open && c != CONF_TOP) return c + 1'b1;
    else                          return c;
  endfunction

  logic tr_hit;

  assign rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_last   = last_q[rd_idx];
  assign rd_stride = stride_q[rd_idx];
  assign rd_sat    = conf_q[rd_idx] == CONF_TOP;

  assign tr_hit   = vld_q[tr_idx] && (tag_q[tr_idx] == tr_tag);
  assign ev_inc   = tr_valid && tr_hit && tr_ok && gate && (conf_q[tr_idx] != CONF_TOP);
  assign ev_clr   = tr_valid && tr_hit && !tr_ok;
  assign ev_al_go = al_valid && !(tr_valid && (tr_idx == al_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
    end else begin
      if (ev_al_go) vld_q[al_idx] <= 1'b1;
      if (tr_valid) vld_q[tr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ev_al_go) begin
      tag_q[al_idx]    <= al_tag;
      last_q[al_idx]   <= '0;
      stride_q[al_idx] <= '0;
      conf_q[al_idx]   <= '0;
    end
    if (tr_valid) begin
      if (tr_hit) begin
        stride_q[tr_idx] <= vp_delta(tr_value, last_q[tr_idx]);
        last_q[tr_idx]   <= tr_value;
        conf_q[tr_idx]   <= conf_after(conf_q[tr_idx], tr_ok, gate);
      end else begin
        tag_q[tr_idx]    <= tr_tag;
        last_q[tr_idx]   <= tr_value;
        stride_q[tr_idx] <= '0;
        conf_q[tr_idx]   <= '0;
      end
    end
  end
endmodule

// File: rtl/svp_window.sv
module svp_window
  import svp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 push,
  input  vp_pc_t               push_pc,
  input  vp_data_t             push_val,
  input  logic                 push_hc,
  input  logic                 pop_req,
  input  vp_pc_t               pop_pc,
  input  vp_pc_t               s_pc,
  output logic                 s_match,
  output vp_data_t             s_val,
  output logic                 s_hc,
  output logic [$clog2(DEPTH):0] count_o,
  output logic                 full_o,
  output logic                 ev_push,
  output logic                 ev_pop
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  vp_pc_t     pc_q  [DEPTH];
  vp_data_t   val_q [DEPTH];
  logic       hc_q  [DEPTH];
  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] count_q;
  logic [PTR_W-1:0] tail;
  logic [PTR_W-1:0] slot;

  assign tail    = head_q + count_q[PTR_W-1:0];
  assign full_o  = count_q == CNT_W'(DEPTH);
  assign count_o = count_q;
  assign ev_push = push && !full_o && !flush;
  assign ev_pop  = pop_req && (count_q != '0) && (pc_q[head_q] == pop_pc) && !flush;

  // youngest match wins: scan oldest to youngest
  always_comb begin
    s_match = 1'b0;
    s_val   = '0;
    s_hc    = 1'b0;
    slot    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      slot = head_q + PTR_W'(i);
      if ((CNT_W'(i) < count_q) && (pc_q[slot] == s_pc)) begin
        s_match = 1'b1;
        s_val   = val_q[slot];
        s_hc    = hc_q[slot];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (ev_pop) head_q <= head_q + 1'b1;
      count_q <= count_q + CNT_W'(ev_push) - CNT_W'(ev_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (ev_push) begin
      pc_q[tail]  <= push_pc;
      val_q[tail] <= push_val;
      hc_q[tail]  <= push_hc;
    end
  end
endmodule

// File: rtl/stride_value_predictor.sv
module stride_value_predictor
  import svp_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int TAG_W     = 8,
  parameter int CONF_W    = 3,
  parameter int WIN_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_rare,
  input  logic        lk_valid,
  input  logic [31:0] lk_pc,
  input  logic        squash,
  input  logic        cm_valid,
  input  logic [31:0] cm_pc,
  input  logic [31:0] cm_value,
  input  logic        cm_ok,
  output logic        pr_valid,
  output logic        pr_hit,
  output logic [31:0] pr_value,
  output logic        pr_use
);
  localparam int IDX_LSB = 2;
  localparam int TAG_LSB = IDX_LSB + IDX_W;
  localparam int CNT_W   = $clog2(WIN_DEPTH) + 1;

  logic [IDX_W-1:0] lk_idx, cm_idx;
  logic [TAG_W-1:0] lk_tag, cm_tag;

  assign lk_idx = lk_pc[IDX_LSB +: IDX_W];
  assign lk_tag = lk_pc[TAG_LSB +: TAG_W];
  assign cm_idx = cm_pc[IDX_LSB +: IDX_W];
  assign cm_tag = cm_pc[TAG_LSB +: TAG_W];

  // named internal events (observed by the checker)
  vp_rng_t  rng_state;
  logic     gate;
  logic     t_hit, t_sat;
  vp_data_t t_last, t_stride;
  logic     ev_inc, ev_clr, ev_al_go;
  logic     w_match, w_hc;
  vp_data_t w_val;
  logic [CNT_W-1:0] w_count;
  logic     w_full, w_push, w_pop;
  logic     al_req;
  vp_data_t base, pred;
  logic     use_c;

  svp_rng_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .rare    (cfg_rare),
    .state_o (rng_state),
    .gate_o  (gate)
  );

  assign al_req = lk_valid && !t_hit;

  svp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CONF_W(CONF_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (lk_idx),
    .rd_tag    (lk_tag),
    .rd_hit    (t_hit),
    .rd_last   (t_last),
    .rd_stride (t_stride),
    .rd_sat    (t_sat),
    .tr_valid  (cm_valid),
    .tr_idx    (cm_idx),
    .tr_tag    (cm_tag),
    .tr_value  (cm_value),
    .tr_ok     (cm_ok),
    .gate      (gate),
    .al_valid  (al_req),
    .al_idx    (lk_idx),
    .al_tag    (lk_tag),
    .ev_inc    (ev_inc),
    .ev_clr    (ev_clr),
    .ev_al_go  (ev_al_go)
  );

  svp_window #(.DEPTH(WIN_DEPTH)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (squash),
    .push     (lk_valid && t_hit),
    .push_pc  (lk_pc),
    .push_val (pred),
    .push_hc  (t_sat),
    .pop_req  (cm_valid),
    .pop_pc   (cm_pc),
    .s_pc     (lk_pc),
    .s_match  (w_match),
    .s_val    (w_val),
    .s_hc     (w_hc),
    .count_o  (w_count),
    .full_o   (w_full),
    .ev_push  (w_push),
    .ev_pop   (w_pop)
  );

  assign base  = w_match ? w_val : t_last;
  assign pred  = vp_extrapolate(base, t_stride);
  assign use_c = t_hit && t_sat && (!w_match || w_hc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_valid <= 1'b0;
      pr_hit   <= 1'b0;
      pr_use   <= 1'b0;
      pr_value <= '0;
    end else begin
      pr_valid <= lk_valid;
      pr_hit   <= lk_valid && t_hit;
      pr_use   <= lk_valid && use_c;
      pr_value <= (lk_valid && t_hit) ? pred : '0;
    end
  end
endmodule

// File: rtl/svp_checker.sv
module svp_checker #(
  parameter int WIN_DEPTH = 8,
  parameter int IDX_W     = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lk_valid,
  input logic                       squash,
  input logic                       cm_valid,
  input logic                       pr_valid,
  input logic                       pr_hit,
  input logic                       pr_use,
  input logic [15:0]                rng_state,
  input logic                       gate,
  input logic                       ev_inc,
  input logic                       al_req,
  input logic                       ev_al_go,
  input logic [IDX_W-1:0]           lk_idx,
  input logic [IDX_W-1:0]           cm_idx,
  input logic [$clog2(WIN_DEPTH):0] w_count,
  input logic                       w_full,
  input logic                       w_pop
);
  p_resp_next_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pr_valid);

  p_use_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pr_use |-> pr_hit);

  p_inc_only_when_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inc |-> gate);

  p_rng_never_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rng_state != 16'h0000);

  p_commit_beats_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (al_req && cm_valid && (lk_idx == cm_idx)) |-> !ev_al_go);

  p_window_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    w_count <= ($clog2(WIN_DEPTH)+1)'(WIN_DEPTH));

  p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_full && !w_pop && !squash) |=> w_full);

  p_squash_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (w_count == '0));
endmodule

bind stride_value_predictor svp_checker #(.WIN_DEPTH(WIN_DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .squash    (squash),
  .cm_valid  (cm_valid),
  .pr_valid  (pr_valid),
  .pr_hit    (pr_hit),
  .pr_use    (pr_use),
  .rng_state (rng_state),
  .gate      (gate),
  .ev_inc    (ev_inc),
  .al_req    (al_req),
  .ev_al_go  (ev_al_go),
  .lk_idx    (lk_idx),
  .cm_idx    (cm_idx),
  .w_count   (w_count),
  .w_full    (w_full),
  .w_pop     (w_pop)
);

// File: tb/stride_value_predictor_tb_top.sv
module stride_value_predictor_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst_n, cfg_rare, lk_valid, squash, cm_valid, cm_ok;
  logic [31:0] lk_pc, cm_pc, cm_value;
  logic        pr_valid, pr_hit, pr_use;
  logic [31:0] pr_value;

  stride_value_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_rare(cfg_rare),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .squash(squash),
    .cm_valid(cm_valid), .cm_pc(cm_pc), .cm_value(cm_value), .cm_ok(cm_ok),
    .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_value(pr_value), .pr_use(pr_use)
  );

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] PC_A = 32'h0000_1204; // index 1
  localparam logic [31:0] PC_B = 32'h0000_3408; // index 2
  localparam logic [31:0] PC_C = 32'h0000_780C; // index 3
  localparam logic [31:0] PC_D = 32'h0000_5610; // index 4
  localparam logic [31:0] PC_J = 32'h0000_2A14; // index 5
  localparam logic [31:0] PC_E = 32'h0000_9904; // index 1, other tag

  // independent model of the random source (R6)
  logic [15:0] m_rng;
  always @(posedge clk) begin
    if (!rst_n) m_rng <= 16'hACE1;
    else        m_rng <= {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
  end

  // table model
  bit          mv     [64];
  logic [7:0]  mtag   [64];
  logic [31:0] mlast  [64];
  logic [31:0] mstep  [64];
  int          mconf  [64];

  function automatic int ix(logic [31:0] pc); return int'(pc[7:2]); endfunction
  function automatic logic [7:0] tg(logic [31:0] pc); return pc[15:8]; endfunction
  function automatic bit m_hit(logic [31:0] pc);
    return mv[ix(pc)] && mtag[ix(pc)] == tg(pc);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_train(logic [31:0] pc, logic [31:0] val, logic ok);
    int  i;
    bit  open;
    i    = ix(pc);
    open = cfg_rare ? (m_rng[7:0] == 8'h00) : (m_rng[4:0] == 5'h00);
    if (m_hit(pc)) begin
      mstep[i] = val - mlast[i];
      mlast[i] = val;
      if (!ok) mconf[i] = 0;
      else if (open && mconf[i] < 7) mconf[i]++;
    end else begin
      mv[i] = 1; mtag[i] = tg(pc); mlast[i] = val; mstep[i] = 0; mconf[i] = 0;
    end
  endtask

  task automatic model_alloc(logic [31:0] pc);
    int i;
    i = ix(pc);
    if (!m_hit(pc)) begin
      mv[i] = 1; mtag[i] = tg(pc); mlast[i] = 0; mstep[i] = 0; mconf[i] = 0;
    end
  endtask

  // all operations start and end at a falling edge
  task automatic do_train(logic [31:0] pc, logic [31:0] val, logic ok);
    cm_valid = 1'b1; cm_pc = pc; cm_value = val; cm_ok = ok;
    model_train(pc, val, ok);
    @(posedge clk); @(negedge clk);
    cm_valid = 1'b0;
  endtask

  task automatic look(logic [31:0] pc, logic sq, string req,
                      output logic h, output logic u, output logic [31:0] v);
    lk_valid = 1'b1; lk_pc = pc; squash = sq;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0; squash = 1'b0;
    chk(req, "pr_valid one cycle after lookup (R1)", {31'd0, pr_valid}, 32'd1);
    h = pr_hit; u = pr_use; v = pr_value;
    model_alloc(pc);
  endtask

  task automatic look_exp(logic [31:0] pc, logic sq, string req,
                          logic eh, logic eu, logic [31:0] ev);
    logic h, u;
    logic [31:0] v;
    look(pc, sq, req, h, u, v);
    chk(req, "pr_hit", {31'd0, h}, {31'd0, eh});
    chk(req, "pr_use", {31'd0, u}, {31'd0, eu});
    chk(req, "pr_value", v, ev);
  endtask

  // expectation from the table model, window assumed empty
  task automatic look_model(logic [31:0] pc, logic sq, string req);
    int i;
    bit eh;
    i  = ix(pc);
    eh = m_hit(pc);
    look_exp(pc, sq, req, eh, eh && mconf[i] == 7, eh ? mlast[i] + mstep[i] : 32'd0);
  endtask

  // train a run to saturation; peek at confidence 6 and 7
  task automatic learn(logic [31:0] pc, logic [31:0] start, logic [31:0] step, string req);
    int i;
    int n;
    bit seen6;
    i = ix(pc); n = 0; seen6 = 0;
    while (mconf[i] != 7 && n < 5000) begin
      do_train(pc, start + step * n, 1'b1);
      n++;
      if (mconf[i] == 6 && !seen6) begin
        seen6 = 1;
        look_model(pc, 1'b1, req);   // not yet usable
      end
    end
    look_model(pc, 1'b1, req);       // now usable
  endtask

  task automatic t_reset;
    chk("R11", "pr_valid after reset", {31'd0, pr_valid}, 32'd0);
    chk("R11", "pr_hit after reset", {31'd0, pr_hit}, 32'd0);
    chk("R11", "pr_use after reset", {31'd0, pr_use}, 32'd0);
  endtask

  task automatic t_alloc;
    look_exp(PC_A, 1'b1, "R1 miss", 1'b0, 1'b0, 32'd0);
    look_model(PC_A, 1'b1, "R7 lookup allocation");
    do_train(PC_J, 32'd500, 1'b1);
    look_model(PC_J, 1'b1, "R7 commit allocation");
  endtask

  task automatic t_learn_common;
    cfg_rare = 1'b0;
    learn(PC_A, 32'd100, 32'd4, "R5 R6 R2 common gate");
  endtask

  task automatic t_chain_retire_squash;
    logic [31:0] l, s, l2;
    l = mlast[ix(PC_A)]; s = mstep[ix(PC_A)];
    look_exp(PC_A, 1'b0, "R3 chain 1", 1'b1, 1'b1, l + s);
    look_exp(PC_A, 1'b0, "R3 chain 2", 1'b1, 1'b1, l + 2*s);
    look_exp(PC_A, 1'b0, "R3 chain 3", 1'b1, 1'b1, l + 3*s);
    do_train(PC_A, l + s, 1'b1);
    look_exp(PC_A, 1'b1, "R3 youngest entry", 1'b1, 1'b1, l + 4*s);
    // window is now empty: the table alone decides
    look_model(PC_A, 1'b1, "R10 squash empties");
    l2 = mlast[ix(PC_A)];
    for (int k = 1; k <= 8; k++)
      look_exp(PC_A, 1'b0, "R9 fill", 1'b1, 1'b1, l2 + k*s);
    look_exp(PC_A, 1'b0, "R9 full drop a", 1'b1, 1'b1, l2 + 9*s);
    look_exp(PC_A, 1'b0, "R9 full drop b", 1'b1, 1'b1, l2 + 9*s);
    do_train(PC_A, l2 + s, 1'b1);  // removes the oldest entry
    look_exp(PC_A, 1'b0, "R10 retire frees slot", 1'b1, 1'b1, l2 + 9*s);
    look_exp(PC_A, 1'b1, "R10 pushed after retire", 1'b1, 1'b1, l2 + 10*s);
  endtask

  task automatic t_mispredict;
    do_train(PC_A, 32'h0000_9000, 1'b0);
    look_model(PC_A, 1'b1, "R5 misprediction clears");
  endtask

  task automatic t_window_conf;
    int i;
    logic [31:0] vb;
    i = ix(PC_B);
    look_model(PC_D, 1'b1, "R7 allocate D");
    while (mconf[i] != 6) do_train(PC_B, 32'd7000 + 32'd12 * mlast[i][7:0], 1'b1);
    look_exp(PC_D, 1'b0, "R9 push D", 1'b1, 1'b0, 32'd0);
    vb = mlast[i] + mstep[i];
    look_exp(PC_B, 1'b0, "R4 push B unsaturated", 1'b1, 1'b0, vb);
    while (mconf[i] != 7) do_train(PC_B, mlast[i] + 32'd12, 1'b1);
    look_exp(PC_B, 1'b1, "R4 window entry not confident", 1'b1, 1'b0, vb + mstep[i]);
    look_model(PC_B, 1'b1, "R4 confident after squash");
  endtask

  task automatic t_rare;
    cfg_rare = 1'b1;
    learn(PC_C, 32'h1000, 32'd8, "R6 rare gate");
    cfg_rare = 1'b0;
  endtask

  task automatic t_collide;
    // lookup of E misses at index 1 while A commits at index 1
    lk_valid = 1'b1; lk_pc = PC_E; squash = 1'b0;
    cm_valid = 1'b1; cm_pc = PC_A; cm_value = 32'h0000_7777; cm_ok = 1'b1;
    model_train(PC_A, 32'h0000_7777, 1'b1);
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0; cm_valid = 1'b0;
    chk("R8", "E lookup misses", {31'd0, pr_hit}, 32'd0);
    look_model(PC_A, 1'b1, "R8 commit kept its entry");
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mv[i] = 0; mtag[i] = '0; mlast[i] = '0; mstep[i] = '0; mconf[i] = 0;
    end
    rst_n = 1'b0; cfg_rare = 1'b0; lk_valid = 1'b0; lk_pc = '0; squash = 1'b0;
    cm_valid = 1'b0; cm_pc = '0; cm_value = '0; cm_ok = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alloc();
    t_learn_common();
    t_chain_retire_squash();
    t_mispredict();
    t_window_conf();
    t_rare();
    t_collide();
    finish_run();
  end
endmodule